// File: doc/BRIEF.md
# Four-Bit ECC Correction Sequencer

This block drives the correction phase of a four-bit-per-sector Reed-Solomon style NAND ECC engine for one 512-byte sector. A pulse on `start` hands it the ten parity bytes that were stored in the spare area. If all ten bytes read as 0xFF, the sector is taken to be freshly erased and no decoding is done. Otherwise the bytes are split into eight 10-bit parity words, and these are pushed into the external syndrome engine, most significant word first.

Once the loads are done and a short settle time has passed, the sequencer looks at the syndrome. A zero syndrome means the sector is clean. A nonzero syndrome starts the error search: the old address result is cleared, the locator is kicked, and the engine status is polled under a bounded timeout. The completion code then decides the outcome. When errors were located, the sequencer walks up to four reported address/value pairs. Each reported address is turned into a byte offset, and every correction that lands inside the data area is emitted as an offset/XOR-mask pair, one per cycle.

The syndrome and locator arithmetic stays outside this block. It is reached through plain load, clear, kick and status signals. A single-cycle `done` pulse carries a signed result code.

Top module: `ecc4_fix_seq`

## Requirements
- R1: When all ten bytes of `parityBytes` equal 0xFF at the `start` pulse, the sequencer makes no load, no clear and no kick, and it pulses `done` with `result` = 0.
- R2: `parityBytes` holds byte k at bits [8k+7:8k]. Parity word k is bit range [10k+9:10k] of that 80-bit vector. The eight words leave on `loadData` in eight consecutive `loadValid` cycles, word 7 first and word 0 last.
- R3: SETTLE_CYC cycles after the last load, `synVals` is sampled. If all of it is zero, `done` pulses with `result` = 0, and neither `addrClr` nor `calcStart` is raised.
- R4: For a nonzero syndrome, `addrClr` is high for exactly one cycle, and `calcStart` is high for the single cycle that follows.
- R5: While `engStatus[11:10]` is nonzero the sequencer keeps polling. It makes at most TIMEOUT polls (default 10240). If the engine is still busy after the last of them, `result` = -1 and no correction is emitted.
- R6: Once the engine is idle, the code in `engStatus[11:8]` decides the outcome. Code 0 ends with `result` = 0. Code 1 (uncorrectable) ends with `result` = -1. Neither emits a correction.
- R7: Codes 2 and 3 give an error count of `engStatus[17:16]` + 1. Errors are taken in index order. Error 0 uses `errAddrLo[9:0]` and `errValLo[7:0]`. Error 1 uses `errAddrLo[25:16]` and `errValLo[23:16]`. Errors 2 and 3 use the same halves of `errAddrHi` and `errValHi`. The final `result` equals this count.
- R8: The byte offset of an error is 519 minus its reported 10-bit address. A correction is emitted only when that offset is below 512. Filtered errors still count in `result`.
- R9: Corrections appear one per cycle on `fixValid`, `fixOffset` and `fixMask`. The last one appears no later than the `done` cycle. `done` is a single-cycle pulse for each accepted start.
- R10: A `start` pulse that arrives while a sequence is in progress has no effect.
- `result` is 4-bit two's complement: 0 means clean, 1 to 4 is the error count, and 4'hF is -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a correction sequence |
| parityBytes | input | 80 | Stored parity bytes, byte k at [8k+7:8k] |
| loadValid | output | 1 | Parity word load strobe to the engine |
| loadData | output | 10 | Parity word being loaded |
| synVals | input | 80 | Eight 10-bit syndrome values from the engine |
| addrClr | output | 1 | Dummy read that clears the previous address result |
| calcStart | output | 1 | Kick the error-location search |
| engStatus | input | 18 | Engine status: [11:10] busy, [11:8] code, [17:16] count-1 |
| errAddrLo | input | 32 | Reported addresses of errors 0 and 1 |
| errAddrHi | input | 32 | Reported addresses of errors 2 and 3 |
| errValLo | input | 32 | Error values of errors 0 and 1 |
| errValHi | input | 32 | Error values of errors 2 and 3 |
| fixValid | output | 1 | Correction valid |
| fixOffset | output | 9 | Byte offset in the sector to correct |
| fixMask | output | 8 | XOR mask for that byte |
| done | output | 1 | Sequence finished |
| result | output | 4 | Signed outcome code |

## Verification
The parity input is tried with an all-0xFF pattern and with one bit cleared from it; the pair shows whether the erased test looks at every bit. A mixed byte pattern checks that each loaded word comes from the right bit slice and in the right order. The engine model is then driven through each completion code, an engine that stays busy forever, and one that stays busy for a while before finishing. These cases tell the clean, uncorrectable and timeout outcomes apart from one another. Error lists with one, two and four entries are used, including addresses that map to offsets 0, 511, 512 and 516, so that selection of the register half, the address reversal and the data-area filter each show up on their own.

// File: rtl/ecc4_pkg.sv
package ecc4_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_LOAD, S_SETTLE, S_SYN, S_CLR, S_KICK, S_POLL, S_DEC, S_FIX, S_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capParity;
    logic loadInit;
    logic loadStep;
    logic capCount;
    logic fixInit;
    logic fixStep;
    logic fixEmit;
  } dpCtl_t;

  localparam logic [3:0] RES_FAIL  = 4'hF;
  localparam logic [3:0] RES_CLEAN = 4'h0;

endpackage

// File: rtl/ecc4_dp.sv
module ecc4_dp
  import ecc4_pkg::*;
#(
  parameter int SECTOR  = 512,
  parameter int ECC_BYTES = 10,
  parameter int VAL_W   = 10,
  localparam int PBITS  = ECC_BYTES * 8,
  localparam int NVALS  = PBITS / VAL_W,
  localparam int IDX_W  = $clog2(NVALS),
  localparam int OFF_W  = $clog2(SECTOR),
  localparam int FW     = VAL_W + 2,
  localparam int BIAS   = SECTOR + 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [PBITS-1:0]   parityIn,
  input  logic [PBITS-1:0]   synVals,
  input  logic [17:0]        engStatus,
  input  logic [31:0]        errAddrLo,
  input  logic [31:0]        errAddrHi,
  input  logic [31:0]        errValLo,
  input  logic [31:0]        errValHi,
  output logic               erased,
  output logic [VAL_W-1:0]   loadData,
  output logic               lastLoad,
  output logic               synZero,
  output logic               engBusy,
  output logic [3:0]         engCode,
  output logic [2:0]         errCount,
  output logic               lastFix,
  output logic               fixValid,
  output logic [OFF_W-1:0]   fixOffset,
  output logic [7:0]         fixMask
);

  logic [PBITS-1:0] parityQ;
  logic [IDX_W-1:0] loadIdx;
  logic [1:0]       fixIdx;
  logic [31:0]      aWord, vWord;
  logic [VAL_W-1:0] rawAddr;
  logic [7:0]       rawVal;
  logic [FW-1:0]    flipped;
  logic             inRange;
  logic             unusedBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parityQ <= '0;
      loadIdx <= '0;
    end else begin
      if (ctl.capParity) parityQ <= parityIn;
      if (ctl.loadInit)      loadIdx <= IDX_W'(NVALS - 1);
      else if (ctl.loadStep) loadIdx <= loadIdx - 1'b1;
    end
  end

  assign erased   = &parityQ;
  assign loadData = parityQ[loadIdx*VAL_W +: VAL_W];
  assign lastLoad = (loadIdx == '0);
  assign synZero  = ~|synVals;

  // status fields
  assign engBusy = |engStatus[11:10];
  assign engCode = engStatus[11:8];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errCount <= '0;
      fixIdx   <= '0;
    end else begin
      if (ctl.capCount) errCount <= 3'(engStatus[17:16]) + 3'd1;
      if (ctl.fixInit)      fixIdx <= '0;
      else if (ctl.fixStep) fixIdx <= fixIdx + 1'b1;
    end
  end

  assign lastFix = (({1'b0, fixIdx} + 3'd1) == errCount);

  // pair select: index bit 1 picks the register, bit 0 the half
  assign aWord   = fixIdx[1] ? errAddrHi : errAddrLo;
  assign vWord   = fixIdx[1] ? errValHi  : errValLo;
  assign rawAddr = fixIdx[0] ? aWord[16 +: VAL_W] : aWord[0 +: VAL_W];
  assign rawVal  = fixIdx[0] ? vWord[23:16] : vWord[7:0];
  assign flipped = FW'(BIAS) - FW'(rawAddr);
  assign inRange = flipped < FW'(SECTOR);

  assign unusedBits = ^{engStatus[15:12], engStatus[7:0], aWord[31:16+VAL_W],
                        aWord[15:VAL_W], vWord[31:24], vWord[15:8]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fixValid  <= 1'b0;
      fixOffset <= '0;
      fixMask   <= '0;
    end else begin
      fixValid  <= ctl.fixEmit & inRange;
      fixOffset <= flipped[OFF_W-1:0];
      fixMask   <= rawVal;
    end
  end

endmodule

// File: rtl/ecc4_ctl.sv
module ecc4_ctl
  import ecc4_pkg::*;
#(
  parameter int TIMEOUT    = 10240,
  parameter int SETTLE_CYC = 2,
  localparam int LIM       = (TIMEOUT > SETTLE_CYC) ? TIMEOUT : SETTLE_CYC,
  localparam int CW        = $clog2(LIM + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       erased,
  input  logic       lastLoad,
  input  logic       synZero,
  input  logic       engBusy,
  input  logic [3:0] engCode,
  input  logic [2:0] errCount,
  input  logic       lastFix,
  output dpCtl_t     ctl,
  output logic       loadValid,
  output logic       addrClr,
  output logic       calcStart,
  output logic       done,
  output logic [3:0] result
);

  seqState_t st, nxt;
  logic [CW-1:0] cnt;
  logic          cntClr, cntInc, finish;
  logic [3:0]    finVal;

  always_comb begin
    nxt    = st;
    ctl    = '0;
    cntClr = 1'b0;
    cntInc = 1'b0;
    finish = 1'b0;
    finVal = RES_CLEAN;
    unique case (st)
      S_IDLE: if (start) begin
        ctl.capParity = 1'b1;
        nxt = S_CHK;
      end
      S_CHK: if (erased) begin
        finish = 1'b1;
      end else begin
        ctl.loadInit = 1'b1;
        nxt = S_LOAD;
      end
      S_LOAD: begin
        ctl.loadStep = 1'b1;
        if (lastLoad) begin
          cntClr = 1'b1;
          nxt = S_SETTLE;
        end
      end
      S_SETTLE: begin
        cntInc = 1'b1;
        if (cnt == CW'(SETTLE_CYC - 1)) nxt = S_SYN;
      end
      S_SYN: if (synZero) finish = 1'b1;
             else nxt = S_CLR;
      S_CLR: nxt = S_KICK;
      S_KICK: begin
        cntClr = 1'b1;
        nxt = S_POLL;
      end
      S_POLL: begin
        cntInc = 1'b1;
        if (!engBusy) nxt = S_DEC;
        else if (cnt == CW'(TIMEOUT - 1)) begin
          finish = 1'b1;
          finVal = RES_FAIL;
        end
      end
      S_DEC: begin
        if (engCode == 4'd0) finish = 1'b1;
        else if (engCode == 4'd1) begin
          finish = 1'b1;
          finVal = RES_FAIL;
        end else begin
          ctl.capCount = 1'b1;
          ctl.fixInit  = 1'b1;
          nxt = S_FIX;
        end
      end
      S_FIX: begin
        ctl.fixEmit = 1'b1;
        ctl.fixStep = 1'b1;
        if (lastFix) begin
          finish = 1'b1;
          finVal = {1'b0, errCount};
        end
      end
      S_DONE: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
    if (finish) nxt = S_DONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= S_IDLE;
      cnt    <= '0;
      result <= RES_CLEAN;
    end else begin
      st <= nxt;
      if (cntClr)      cnt <= '0;
      else if (cntInc) cnt <= cnt + 1'b1;
      if (finish) result <= finVal;
    end
  end

  assign loadValid = (st == S_LOAD);
  assign addrClr   = (st == S_CLR);
  assign calcStart = (st == S_KICK);
  assign done      = (st == S_DONE);

endmodule

// File: rtl/ecc4_fix_seq.sv
module ecc4_fix_seq
  import ecc4_pkg::*;
#(
  parameter int SECTOR     = 512,
  parameter int ECC_BYTES  = 10,
  parameter int VAL_W      = 10,
  parameter int TIMEOUT    = 10240,
  parameter int SETTLE_CYC = 2,
  localparam int PBITS     = ECC_BYTES * 8,
  localparam int OFF_W     = $clog2(SECTOR)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [PBITS-1:0]  parityBytes,
  output logic              loadValid,
  output logic [VAL_W-1:0]  loadData,
  input  logic [PBITS-1:0]  synVals,
  output logic              addrClr,
  output logic              calcStart,
  input  logic [17:0]       engStatus,
  input  logic [31:0]       errAddrLo,
  input  logic [31:0]       errAddrHi,
  input  logic [31:0]       errValLo,
  input  logic [31:0]       errValHi,
  output logic              fixValid,
  output logic [OFF_W-1:0]  fixOffset,
  output logic [7:0]        fixMask,
  output logic              done,
  output logic [3:0]        result
);

  dpCtl_t     ctl;
  logic       erased, lastLoad, synZero, engBusy, lastFix;
  logic [3:0] engCode;
  logic [2:0] errCount;

  ecc4_ctl #(.TIMEOUT(TIMEOUT), .SETTLE_CYC(SETTLE_CYC)) i_ctl (
    .clk(clk), .rstN(rstN), .start(start),
    .erased(erased), .lastLoad(lastLoad), .synZero(synZero),
    .engBusy(engBusy), .engCode(engCode), .errCount(errCount), .lastFix(lastFix),
    .ctl(ctl), .loadValid(loadValid), .addrClr(addrClr), .calcStart(calcStart),
    .done(done), .result(result)
  );

  ecc4_dp #(.SECTOR(SECTOR), .ECC_BYTES(ECC_BYTES), .VAL_W(VAL_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .parityIn(parityBytes), .synVals(synVals), .engStatus(engStatus),
    .errAddrLo(errAddrLo), .errAddrHi(errAddrHi),
    .errValLo(errValLo), .errValHi(errValHi),
    .erased(erased), .loadData(loadData), .lastLoad(lastLoad),
    .synZero(synZero), .engBusy(engBusy), .engCode(engCode),
    .errCount(errCount), .lastFix(lastFix),
    .fixValid(fixValid), .fixOffset(fixOffset), .fixMask(fixMask)
  );

endmodule

// File: rtl/ecc4_fix_seq_chk.sv
module ecc4_fix_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       loadValid,
  input logic       addrClr,
  input logic       calcStart,
  input logic       fixValid,
  input logic       done,
  input logic [3:0] result
);

  logic [3:0] ldCnt;
  logic [2:0] fxCnt;

  always_ff @(posedge clk) begin
    if (!rstN || done) begin
      ldCnt <= '0;
      fxCnt <= '0;
    end else begin
      if (loadValid) ldCnt <= ldCnt + 1'b1;
      if (fixValid)  fxCnt <= fxCnt + 1'b1;
    end
  end

  // R2: a sequence loads either nothing or all eight words
  a_r2_eight_loads: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (ldCnt == 4'd0 || ldCnt == 4'd8));

  // R4: clear comes right before the kick and lasts one cycle
  a_r4_clr_then_kick: assert property (@(posedge clk) disable iff (!rstN)
    calcStart |-> $past(addrClr));
  a_r4_clr_single: assert property (@(posedge clk) disable iff (!rstN)
    addrClr |=> (!addrClr && calcStart));

  // R6: failing outcomes emit no correction
  a_r6_fail_no_fix: assert property (@(posedge clk) disable iff (!rstN)
    (done && result == 4'hF) |-> (fxCnt == 3'd0 && !fixValid));

  // R7: never more than four corrections per sequence
  a_r7_fix_bound: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ({1'b0, fxCnt} + 4'(fixValid)) <= 4'd4);

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind ecc4_fix_seq ecc4_fix_seq_chk i_chk (
  .clk(clk), .rstN(rstN), .loadValid(loadValid), .addrClr(addrClr),
  .calcStart(calcStart), .fixValid(fixValid), .done(done), .result(result)
);

// File: tb/test_ecc4_fix_seq.sv
module test_ecc4_fix_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [79:0] parityBytes = '0;
  logic        loadValid;
  logic [9:0]  loadData;
  logic [79:0] synVals = '0;
  logic        addrClr, calcStart;
  logic [17:0] engStatus;
  logic [31:0] errAddrLo = '0, errAddrHi = '0, errValLo = '0, errValHi = '0;
  logic        fixValid;
  logic [8:0]  fixOffset;
  logic [7:0]  fixMask;
  logic        done;
  logic [3:0]  result;

  always #4 clk = ~clk;

  ecc4_fix_seq i_ecc4_fix_seq (
    .clk(clk), .rstN(rstN), .start(start), .parityBytes(parityBytes),
    .loadValid(loadValid), .loadData(loadData), .synVals(synVals),
    .addrClr(addrClr), .calcStart(calcStart), .engStatus(engStatus),
    .errAddrLo(errAddrLo), .errAddrHi(errAddrHi),
    .errValLo(errValLo), .errValHi(errValHi),
    .fixValid(fixValid), .fixOffset(fixOffset), .fixMask(fixMask),
    .done(done), .result(result)
  );

  // engine model
  logic [17:0] finalStatus = '0;
  logic        busyForever = 1'b0;
  int          busyLen = 2;
  int          pollLeft = 0;
  always @(posedge clk) begin
    if (calcStart) pollLeft <= busyLen;
    else if (pollLeft > 0) pollLeft <= pollLeft - 1;
  end
  assign engStatus = (busyForever || pollLeft > 0) ? 18'h00C00 : finalStatus;

  // monitors
  int nChk = 0, nFail = 0;
  int cyc = 0;
  int ldN, fxN, clrN, kickN, doneN, resSeen, doneCyc;
  int ldLog[16];
  int fxOff[8];
  int fxMsk[8];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (loadValid) begin
      if (ldN < 16) ldLog[ldN] = int'(loadData);
      ldN = ldN + 1;
    end
    if (fixValid) begin
      if (fxN < 8) begin
        fxOff[fxN] = int'(fixOffset);
        fxMsk[fxN] = int'(fixMask);
      end
      fxN = fxN + 1;
    end
    if (addrClr) clrN = clrN + 1;
    if (calcStart) kickN = kickN + 1;
    if (done) begin
      doneN = doneN + 1;
      resSeen = int'(result);
      doneCyc = cyc;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearLog();
    ldN = 0; fxN = 0; clrN = 0; kickN = 0; doneN = 0; resSeen = -99;
  endtask

  // expected parity word k, gathered bit by bit from the byte layout
  function automatic int expWord(input logic [79:0] p, input int k);
    int v = 0;
    for (int j = 0; j < 10; j++) begin
      int pos = 10 * k + j;
      logic [7:0] b = p[8 * (pos / 8) +: 8];
      if (b[pos % 8]) v = v | (1 << j);
    end
    return v;
  endfunction

  int startCyc;
  task automatic runSeq(input logic [79:0] p);
    clearLog();
    @(negedge clk);
    parityBytes = p;
    start = 1'b1;
    startCyc = cyc;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20000 && doneN == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  localparam logic [79:0] PAT = 80'h0123_4567_89AB_CDEF_F00D;

  task automatic t_reset();
    chk("reset done", int'(done), 0);
    chk("reset loadValid", int'(loadValid), 0);
    chk("reset fixValid", int'(fixValid), 0);
    chk("reset addrClr", int'(addrClr | calcStart), 0);
  endtask

  task automatic t_erased();
    synVals = 80'h1;
    runSeq({80{1'b1}});
    chk("R1 erased result", resSeen, 0);
    chk("R1 erased loads", ldN, 0);
    chk("R1 erased kicks", clrN + kickN, 0);
    runSeq({{79{1'b1}}, 1'b0});
    chk("R1 near-erased loads", ldN, 8);
  endtask

  task automatic t_load_order();
    synVals = '0;
    runSeq(PAT);
    chk("R2 load count", ldN, 8);
    for (int i = 0; i < 8; i++) chk("R2 load word", ldLog[i], expWord(PAT, 7 - i));
    chk("R3 zero syndrome result", resSeen, 0);
    chk("R3 zero syndrome no clear/kick", clrN + kickN, 0);
  endtask

  task automatic t_code_clean();
    synVals = 80'h4; busyLen = 3; finalStatus = 18'h00000;
    runSeq(PAT);
    chk("R4 one clear", clrN, 1);
    chk("R4 one kick", kickN, 1);
    chk("R6 code0 result", resSeen, 0);
    chk("R6 code0 fixes", fxN, 0);
  endtask

  task automatic t_code_uncorr();
    synVals = 80'h4; busyLen = 3; finalStatus = 18'h00100;
    runSeq(PAT);
    chk("R6 code1 result", resSeen, 15);
    chk("R6 code1 fixes", fxN, 0);
  endtask

  task automatic t_four_errors();
    synVals = 80'h4; busyLen = 2; finalStatus = 18'h30300;
    errAddrLo = 32'h0008_0207; errValLo = 32'h0022_0011;
    errAddrHi = 32'h0064_0007; errValHi = 32'h0044_0033;
    runSeq(PAT);
    chk("R7 four result", resSeen, 4);
    chk("R8 four emitted", fxN, 3);
    chk("R8 offset 0", fxOff[0], 0);
    chk("R7 mask 0", fxMsk[0], 8'h11);
    chk("R8 offset 511", fxOff[1], 511);
    chk("R7 mask 1", fxMsk[1], 8'h22);
    chk("R8 offset 419", fxOff[2], 419);
    chk("R7 mask 3", fxMsk[2], 8'h44);
    chk("R9 single done", doneN, 1);
  endtask

  task automatic t_parity_only();
    synVals = 80'h4; busyLen = 2; finalStatus = 18'h00200;
    errAddrLo = 32'h0000_0003; errValLo = 32'h0000_00FF;
    runSeq(PAT);
    chk("R8 filtered result", resSeen, 1);
    chk("R8 filtered fixes", fxN, 0);
  endtask

  task automatic t_two_errors();
    synVals = 80'h4; busyLen = 2; finalStatus = 18'h10300;
    errAddrLo = 32'h0009_01F4; errValLo = 32'h00AA_0055;
    errAddrHi = 32'h00C8_00C8; errValHi = 32'h00FF_00FF;
    runSeq(PAT);
    chk("R7 two result", resSeen, 2);
    chk("R7 two emitted", fxN, 2);
    chk("R7 first offset", fxOff[0], 19);
    chk("R7 first mask", fxMsk[0], 8'h55);
    chk("R7 second offset", fxOff[1], 510);
    chk("R7 second mask", fxMsk[1], 8'hAA);
  endtask

  task automatic t_timeout();
    synVals = 80'h4; busyForever = 1'b1;
    runSeq(PAT);
    chk("R5 timeout result", resSeen, 15);
    chk("R5 timeout fixes", fxN, 0);
    chk("R5 polled long enough", int'(doneCyc - startCyc >= 10240), 1);
    chk("R5 not too long", int'(doneCyc - startCyc < 10300), 1);
    busyForever = 1'b0;
  endtask

  task automatic t_slow_busy();
    synVals = 80'h4; busyLen = 50; finalStatus = 18'h00300;
    errAddrLo = 32'h0000_0207; errValLo = 32'h0000_0080;
    runSeq(PAT);
    chk("R5 slow busy result", resSeen, 1);
    chk("R5 slow busy fix offset", fxOff[0], 0);
    chk("R5 slow busy fix mask", fxMsk[0], 8'h80);
  endtask

  task automatic t_restart();
    synVals = '0;
    clearLog();
    @(negedge clk);
    parityBytes = PAT; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    parityBytes = {80{1'b1}}; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    chk("R10 restart loads", ldN, 8);
    chk("R10 restart first word", ldLog[0], expWord(PAT, 7));
    chk("R10 restart last word", ldLog[7], expWord(PAT, 0));
    chk("R10 restart dones", doneN, 1);
  endtask

  initial begin
    clearLog();
    repeat (4) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_erased();
    t_load_order();
    t_code_clean();
    t_code_uncorr();
    t_four_errors();
    t_parity_only();
    t_two_errors();
    t_slow_busy();
    t_restart();
    t_timeout();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    #(8 * 190000);
    nChk++;
    nFail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule